// File: doc/BRIEF.md
# Flow-Controlled Streaming Read Port

This block sits between a sparse producer of 32-bit sample words and a DMA engine that empties them from one fixed bus address into memory. A producer strobe loads a word into a holding register. An active-low availability flag then tells the DMA that a word is waiting. The DMA reads the port with chip-select and an active-low read strobe. The flag is withdrawn on the first system clock edge at which the read is sampled, so each word is handed over exactly once. The producer, the bus and the port all run on one system clock.

The two low bits of every word carry a wrapping sequence tag. A receive-side checker watches each accepted word. It compares the tag with the previous one and pulses a duplicate or skip indication when the step is not exactly one.

The holder runs on three states. ST_EMPTY drives the flag high; on a producer strobe it goes to ST_HELD, or to ST_STALE if a bus read is still active in that cycle. ST_STALE holds the word with the flag low; once the read is seen inactive it goes to ST_HELD. ST_HELD holds the word with the flag low; when a read is accepted it returns to ST_EMPTY. The checker has two states. CK_FIRST waits for the first accepted word and goes to CK_TRACK on it. CK_TRACK compares every later tag and stays there until reset.

Top module: `stream_rd_port`

## Requirements
- R1: The reset is synchronous and active-high. After reset, avail_n is 1, rd_data is 0, and overflow, tag_dup and tag_skip are 0.
- R2: A producer strobe sampled while avail_n is 1 loads prod_word. From the following cycle, rd_data shows that word and avail_n is 0.
- R3: A read is accepted at a clock edge where bus_cs is 1, bus_rd_n is 0 and the word is armed. From the next cycle, avail_n is 1.
- R4: A read strobe with bus_cs at 0 is ignored. avail_n stays 0 and rd_data is unchanged.
- R5: Only one word is accepted per active read strobe. If the strobe is still active when a new word is loaded, that word is not accepted until the strobe has been sampled inactive and then sampled active again.
- R6: A producer strobe while avail_n is 0 leaves rd_data unchanged. It sets overflow to 1, and overflow stays 1 until reset.
- R7: While avail_n is 1, it stays 1 until a producer strobe arrives. Reads in that time are not accepted.
- R8: The tag is bits [1:0] of the word. If an accepted word's tag equals the previous accepted tag, tag_dup is 1 for exactly the cycle after the accepting edge.
- R9: If an accepted tag minus the previous tag, taken modulo 4, is 2 or 3, tag_skip pulses for that same cycle. A step of 1 raises neither output, and the two outputs are never raised together.
- R10: The first word accepted after reset raises neither tag_dup nor tag_skip, whatever tag came before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by producer and bus |
| rst | input | 1 | Synchronous active-high reset |
| prod_valid | input | 1 | Producer strobe, one cycle per new word |
| prod_word | input | 32 | Producer word, low 2 bits are the sequence tag |
| bus_cs | input | 1 | Bus chip-select for the port |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| rd_data | output | 32 | Held word presented to the bus |
| avail_n | output | 1 | Word-available flag, active low |
| overflow | output | 1 | Sticky: a word arrived while one was pending |
| tag_dup | output | 1 | One-cycle pulse: accepted tag repeated |
| tag_skip | output | 1 | One-cycle pulse: accepted tag jumped by 2 or more |

## Verification
Words are delivered with every tag step from 0 to 3. This is combined with idle gaps of one to three cycles and read strobes held one to three cycles. Together these separate a correct single acceptance from a double read on a long strobe, and a correct +1 step from duplicate and skip reports. Further patterns cover reads without chip-select, reads of an empty port, a word loaded while the strobe is still low, and a producer strobe over a pending word. These show that ignored reads change nothing, that stale strobes are not counted, and that the overflow bit sticks. A reset followed by a repeat of the last tag shows that the tag history is cleared.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HELD  = 2'd1,
        ST_STALE = 2'd2
    } srp_hold_t;

    typedef enum logic {
        CK_FIRST = 1'b0,
        CK_TRACK = 1'b1
    } srp_chk_t;

endpackage

// File: rtl/srp_holder.sv
module srp_holder
    import srp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_valid,
    input  logic [DATA_W-1:0] prod_word,
    input  logic              rd_act,
    output logic [DATA_W-1:0] word_q,
    output logic              avail_n,
    output logic              accept,
    output logic              overflow
);

    srp_hold_t state_q, state_d;
    logic      load;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (prod_valid) state_d = rd_act ? ST_STALE : ST_HELD;
            ST_STALE: if (!rd_act)    state_d = ST_HELD;
            ST_HELD:  if (rd_act)     state_d = ST_EMPTY;
            default:                  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        avail_n = (state_q == ST_EMPTY);
        load    = (state_q == ST_EMPTY) && prod_valid;
        accept  = (state_q == ST_HELD) && rd_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            overflow <= 1'b0;
        end else begin
            if (load) word_q <= prod_word;
            if (!avail_n && prod_valid) overflow <= 1'b1;
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (avail_n && prod_valid) |=> (!avail_n && word_q == $past(prod_word)));

    p_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HELD && rd_act) |=> avail_n);

    p_keep_word_r4: assert property (@(posedge clk) disable iff (rst)
        (!avail_n && !rd_act) |=> (!avail_n && $stable(word_q)));

    p_stale_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STALE) |=> !avail_n);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (avail_n && !prod_valid) |=> avail_n);

endmodule

// File: rtl/srp_tag_check.sv
module srp_tag_check
    import srp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [DATA_W-1:0] word,
    output logic              tag_dup,
    output logic              tag_skip
);

    localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);

    srp_chk_t         ck_q, ck_d;
    logic [TAG_W-1:0] prev_q;
    logic [TAG_W-1:0] step;
    logic             dup_d, skip_d;

    always_comb begin
        ck_d = ck_q;
        unique case (ck_q)
            CK_FIRST: if (accept) ck_d = CK_TRACK;
            CK_TRACK: ck_d = CK_TRACK;
            default:  ck_d = CK_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ck_q <= CK_FIRST;
        else     ck_q <= ck_d;
    end

    always_comb begin
        step   = word[TAG_W-1:0] - prev_q;
        dup_d  = accept && (ck_q == CK_TRACK) && (step == '0);
        skip_d = accept && (ck_q == CK_TRACK) && (step != '0) && (step != TAG_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            tag_dup  <= 1'b0;
            tag_skip <= 1'b0;
        end else begin
            if (accept) prev_q <= word[TAG_W-1:0];
            tag_dup  <= dup_d;
            tag_skip <= skip_d;
        end
    end

    p_pulse_only_r8: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (!tag_dup && !tag_skip));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tag_dup, tag_skip}));

    p_first_clean_r10: assert property (@(posedge clk) disable iff (rst)
        (ck_q == CK_FIRST && accept) |=> (!tag_dup && !tag_skip));

endmodule

// File: rtl/stream_rd_port.sv
module stream_rd_port #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_valid,
    input  logic [DATA_W-1:0] prod_word,
    input  logic              bus_cs,
    input  logic              bus_rd_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              avail_n,
    output logic              overflow,
    output logic              tag_dup,
    output logic              tag_skip
);

    logic rd_act;
    logic accept;

    assign rd_act = bus_cs && !bus_rd_n;

    srp_holder #(.DATA_W(DATA_W)) u_holder (
        .clk        (clk),
        .rst        (rst),
        .prod_valid (prod_valid),
        .prod_word  (prod_word),
        .rd_act     (rd_act),
        .word_q     (rd_data),
        .avail_n    (avail_n),
        .accept     (accept),
        .overflow   (overflow)
    );

    srp_tag_check #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_check (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .word     (rd_data),
        .tag_dup  (tag_dup),
        .tag_skip (tag_skip)
    );

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (avail_n && !overflow && !tag_dup && !tag_skip && rd_data == '0));

endmodule

// File: tb/stream_rd_port_tb_top.sv
module stream_rd_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prod_valid = 1'b0;
    logic [31:0] prod_word = '0;
    logic        bus_cs = 1'b0;
    logic        bus_rd_n = 1'b1;
    logic [31:0] rd_data;
    logic        avail_n, overflow, tag_dup, tag_skip;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    stream_rd_port dut_i (
        .clk(clk), .rst(rst), .prod_valid(prod_valid), .prod_word(prod_word),
        .bus_cs(bus_cs), .bus_rd_n(bus_rd_n), .rd_data(rd_data),
        .avail_n(avail_n), .overflow(overflow), .tag_dup(tag_dup), .tag_skip(tag_skip)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // producer strobe for one cycle, then check R2
    task automatic deliver(input logic [31:0] w);
        @(negedge clk); prod_valid = 1'b1; prod_word = w;
        @(negedge clk); prod_valid = 1'b0;
        chk(avail_n == 1'b0, "R2 avail_n", 32'(avail_n), 32'd0);
        chk(rd_data == w, "R2 rd_data", rd_data, w);
    endtask

    // read strobe held len cycles; returns pulses seen after the accepting edge
    task automatic read_word(input int len, output logic d, output logic s);
        @(negedge clk); bus_cs = 1'b1; bus_rd_n = 1'b0;
        @(negedge clk);
        chk(avail_n == 1'b1, "R3 avail_n after read", 32'(avail_n), 32'd1);
        d = tag_dup; s = tag_skip;
        for (int k = 1; k < len; k++) begin
            @(negedge clk);
            chk(avail_n == 1'b1, "R7 flag stays high under long strobe", 32'(avail_n), 32'd1);
            chk(!tag_dup && !tag_skip, "R8 single pulse", {30'd0, tag_dup, tag_skip}, 32'd0);
        end
        bus_cs = 1'b0; bus_rd_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [1:0]  prev;
        bit          have_prev;
        logic        d, s;
        logic [31:0] w;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(avail_n == 1'b1, "R1 avail_n", 32'(avail_n), 32'd1);
        chk(rd_data == 32'd0, "R1 rd_data", rd_data, 32'd0);
        chk(!overflow && !tag_dup && !tag_skip, "R1 flags", {29'd0, overflow, tag_dup, tag_skip}, 32'd0);

        // R7: read of an empty port is not accepted
        @(negedge clk); bus_cs = 1'b1; bus_rd_n = 1'b0;
        @(negedge clk); bus_cs = 1'b0; bus_rd_n = 1'b1;
        @(negedge clk);
        chk(avail_n == 1'b1, "R7 empty read", 32'(avail_n), 32'd1);

        // sweep tag steps x gaps x strobe lengths
        prev = 2'd0; have_prev = 1'b0;
        for (int st = 0; st < 4; st++) begin
            for (int gap = 1; gap <= 3; gap++) begin
                logic [1:0] tag;
                bit ed, es;
                tag = prev + 2'(st);
                w = {st[7:0], gap[7:0], 14'h1a5, 2'b00} | {30'd0, tag};
                repeat (gap) @(negedge clk);
                chk(avail_n == 1'b1, "R7 idle gap", 32'(avail_n), 32'd1);
                deliver(w);
                if (gap == 2) begin
                    // R4: strobe without chip-select
                    @(negedge clk); bus_rd_n = 1'b0;
                    @(negedge clk); bus_rd_n = 1'b1;
                    chk(avail_n == 1'b0, "R4 avail_n", 32'(avail_n), 32'd0);
                    chk(rd_data == w, "R4 rd_data", rd_data, w);
                end
                read_word(gap, d, s);
                ed = have_prev && (tag == prev);
                es = have_prev && (2'(tag - prev) >= 2'd2);
                chk(d == ed, have_prev ? "R8 dup" : "R10 first dup", 32'(d), 32'(ed));
                chk(s == es, have_prev ? "R9 skip" : "R10 first skip", 32'(s), 32'(es));
                @(negedge clk);
                chk(!tag_dup && !tag_skip, "R8 pulse ends", {30'd0, tag_dup, tag_skip}, 32'd0);
                prev = tag; have_prev = 1'b1;
            end
        end

        // R5: word loaded while strobe still active is not accepted by it
        deliver({30'h2aaa, 2'(prev + 2'd1)});
        prev = prev + 2'd1;
        @(negedge clk); bus_cs = 1'b1; bus_rd_n = 1'b0;
        @(negedge clk);
        chk(avail_n == 1'b1, "R3 accept", 32'(avail_n), 32'd1);
        w = {30'h3bbb, 2'(prev + 2'd1)};
        prod_valid = 1'b1; prod_word = w;
        @(negedge clk); prod_valid = 1'b0;
        repeat (3) begin
            chk(avail_n == 1'b0, "R5 stale strobe ignored", 32'(avail_n), 32'd0);
            @(negedge clk);
        end
        bus_cs = 1'b0; bus_rd_n = 1'b1;
        @(negedge clk);
        chk(avail_n == 1'b0 && rd_data == w, "R5 word kept", rd_data, w);
        read_word(1, d, s);
        chk(!d && !s, "R9 step of one", {30'd0, d, s}, 32'd0);
        prev = prev + 2'd1;

        // R6: overflow on pending word
        deliver({30'h1234, 2'(prev + 2'd1)});
        w = rd_data;
        @(negedge clk); prod_valid = 1'b1; prod_word = 32'hdeadbeef;
        @(negedge clk); prod_valid = 1'b0;
        chk(rd_data == w, "R6 word kept", rd_data, w);
        chk(overflow == 1'b1, "R6 overflow set", 32'(overflow), 32'd1);
        read_word(1, d, s);
        repeat (4) @(negedge clk);
        chk(overflow == 1'b1, "R6 overflow sticky", 32'(overflow), 32'd1);
        prev = prev + 2'd1;

        // R10: reset clears history; repeat of last tag gives no report
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(avail_n && !overflow && rd_data == 32'd0, "R1 second reset", {31'd0, overflow}, 32'd0);
        deliver({30'h0777, prev});
        read_word(1, d, s);
        chk(!d && !s, "R10 history cleared", {30'd0, d, s}, 32'd0);
        deliver({30'h0778, prev});
        read_word(2, d, s);
        chk(d == 1'b1 && s == 1'b0, "R8 dup after reset", {30'd0, d, s}, 32'd2);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule